// File: doc/BRIEF.md
# Serial EEPROM Slave

This block is the device side of a three-wire synchronous serial memory link: a select line, a serial clock, a data input and a data output. Behind the link sits a 1024-bit array that is organized either as 64 words of 16 bits or as 128 words of 8 bits, chosen at elaboration. The host raises select, sends a start bit, an opcode and an address, and then either shifts in a data word or shifts out the addressed word. Programming is committed when select falls after a complete instruction. A busy period follows, measured in system clock cycles. The host finds out when programming is done by raising select and watching the data output.

The serial pins are sampled by the system clock `clk`. A serial clock rising edge is detected as the sample where `sk` is high and was low on the previous sample, while `cs` is high. The pins carry no valid/ready handshake and there is no back-pressure. The host sets the pace with `sk`, and an instruction sent while the device is busy is dropped. `dout_en` marks the cycles in which `dout` is driven; a pad would tristate `dout` whenever `dout_en` is low.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `dout_en` is 0, programming is disabled, and every word of the array reads as all ones.
- R2: While `cs` is high and the frontend is idle, zeros sampled on `di` are skipped. The first 1 is the start bit. An instruction is the start bit, 2 opcode bits and AW address bits, which is 9 bits for 16-bit words and 10 bits for 8-bit words. All fields are sent MSB first and sampled on rising `sk`.
- R3: Opcode encoding: 10 is read, 01 is write and 11 is erase. Opcode 00 is decoded by the top two address bits: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes one word to the whole array.
- R4: A read drives a 0 dummy bit from the rising edge that takes the last address bit. Each of the next DW rising edges presents one data bit, MSB first. The rising edge after the LSB releases `dout_en`.
- R5: A write takes DW data bits after the address, MSB first. The word is stored when `cs` falls after the last data bit.
- R6: Erase sets the addressed word to all ones. Erase-all sets every word to all ones.
- R7: Write-all stores its DW-bit data word into every word of the array.
- R8: Write, erase, erase-all and write-all do nothing unless programming is enabled. A blocked operation starts no busy period and no status. Enable and disable take effect at the falling `cs` that ends them.
- R9: An accepted programming operation keeps the device busy for exactly BUSY_CYCLES clock cycles. Whenever `cs` is high and no instruction is in progress after such an operation, `dout_en` is 1 and `dout` shows 0 while busy and 1 when ready. This lasts until the next accepted start bit.
- R10: While busy, start bits are ignored, so an instruction sent during the busy period changes neither the array nor the enable state, and produces no read data.
- R11: `cs` falling before an instruction is complete abandons it with no effect. `dout_en` is 0 on the cycle after `cs` is seen low.
- R12: `dout_en` is 1 only during read output or busy/ready status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | High when `dout` is driven |

## Verification
The bench attacks the end of a read. A frontend that miscounts the dummy bit shifts every word by one place, and one that keeps driving after the LSB holds `dout_en` high into the hold state. It sends a full instruction while busy. A design that accepts start bits then would erase a word or return read data, and a busy timer that is one cycle short or long moves the status 0-to-1 edge. It also drops `cs` in the middle of a data word and sends writes while programming is disabled. A design that commits on partial frames, or that ignores the enable latch, alters words that should still read back unchanged.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [2:0] {
    FE_IDLE,
    FE_HDR,
    FE_DATA,
    FE_READ,
    FE_ARMED,
    FE_HOLD
  } fe_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_ERASE,
    CMD_WRALL,
    CMD_ERALL,
    CMD_WEN,
    CMD_WDIS
  } cmd_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDIS  = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/seep_busy_timer.sv
module seep_busy_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int BW = $clog2(CYCLES + 1);

  logic [BW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (start)          left <= BW'(CYCLES);
    else if (left != '0)     left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/seep_store.sv
module seep_store
  import seep_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  cmd_e          kind,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DEPTH-1:0][DW-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = (waddr == AW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else if (go) begin
        if (kind == CMD_WRALL)                   q <= wdata;
        else if (kind == CMD_ERALL)              q <= '1;
        else if (hit && kind == CMD_WRITE)       q <= wdata;
        else if (hit && kind == CMD_ERASE)       q <= '1;
      end
    end
    assign words[w] = q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/seep_frontend.sv
module seep_frontend
  import seep_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] look_addr,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output cmd_e          prog_kind,
  output logic          prog_go,
  output logic          rd_active,
  output logic          rd_bit,
  output logic          status_show,
  output logic          idle
);
  localparam int HW   = 2 + AW;
  localparam int CMAX = (HW > DW) ? HW : DW;
  localparam int CW   = $clog2(CMAX + 1);

  fe_state_e      st;
  cmd_e           pend;
  logic           cs_q, sk_q, wen, stat;
  logic [HW-1:0]  hdr, hdr_nx;
  logic [DW-1:0]  dat;
  logic [DW:0]    osr;
  logic [CW-1:0]  cnt;
  logic           sk_rise, cs_fall, is_prog;
  logic [1:0]     opc, sub;

  assign sk_rise   = cs & sk & ~sk_q;
  assign cs_fall   = cs_q & ~cs;
  assign hdr_nx    = {hdr[HW-2:0], di};
  assign look_addr = hdr_nx[AW-1:0];
  assign opc       = hdr_nx[HW-1:HW-2];
  assign sub       = hdr_nx[AW-1:AW-2];
  assign is_prog   = (pend == CMD_WRITE) || (pend == CMD_ERASE) ||
                     (pend == CMD_WRALL) || (pend == CMD_ERALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FE_IDLE;  pend <= CMD_NONE;
      cs_q <= 1'b0;   sk_q <= 1'b0;  wen <= 1'b0;  stat <= 1'b0;
      hdr <= '0;      dat <= '0;     osr <= '0;    cnt <= '0;
      prog_addr <= '0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      if (!cs) begin
        st <= FE_IDLE;
        if (cs_fall && st == FE_ARMED) begin
          if (pend == CMD_WEN)       wen  <= 1'b1;
          else if (pend == CMD_WDIS) wen  <= 1'b0;
          else if (wen && is_prog)   stat <= 1'b1;
        end
      end else if (sk_rise) begin
        unique case (st)
          FE_IDLE: if (di && !busy) begin
            st   <= FE_HDR;
            cnt  <= '0;
            stat <= 1'b0;
          end
          FE_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              prog_addr <= hdr_nx[AW-1:0];
              cnt       <= '0;
              unique case (opc)
                OPC_READ:  begin st <= FE_READ;  osr  <= {1'b0, rd_word}; pend <= CMD_NONE; end
                OPC_WRITE: begin st <= FE_DATA;  pend <= CMD_WRITE; end
                OPC_ERASE: begin st <= FE_ARMED; pend <= CMD_ERASE; end
                default: begin
                  unique case (sub)
                    SUB_WEN:   begin st <= FE_ARMED; pend <= CMD_WEN;   end
                    SUB_WDIS:  begin st <= FE_ARMED; pend <= CMD_WDIS;  end
                    SUB_ERALL: begin st <= FE_ARMED; pend <= CMD_ERALL; end
                    default:   begin st <= FE_DATA;  pend <= CMD_WRALL; end
                  endcase
                end
              endcase
            end
          end
          FE_DATA: begin
            dat <= {dat[DW-2:0], di};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) st <= FE_ARMED;
          end
          FE_READ: begin
            if (cnt == CW'(DW)) st <= FE_HOLD;
            else begin
              osr <= {osr[DW-1:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign prog_go     = cs_fall && (st == FE_ARMED) && wen && is_prog;
  assign prog_kind   = pend;
  assign prog_data   = dat;
  assign rd_active   = (st == FE_READ);
  assign rd_bit      = osr[DW];
  assign idle        = (st == FE_IDLE);
  assign status_show = cs_q && idle && stat;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import seep_pkg::*;
#(
  parameter bit WIDE_WORDS  = 1'b1,
  parameter int TOTAL_BITS  = 1024,
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_en
);
  localparam int DW    = WIDE_WORDS ? 16 : 8;
  localparam int DEPTH = TOTAL_BITS / DW;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0] look_addr, prog_addr;
  logic [DW-1:0] rd_word, prog_data;
  cmd_e          prog_kind;
  logic          prog_go, rd_active, rd_bit, status_show, fe_idle, busy;

  seep_frontend #(.DW(DW), .AW(AW)) u_fe (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .busy(busy),
    .rd_word(rd_word), .look_addr(look_addr), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_kind(prog_kind), .prog_go(prog_go),
    .rd_active(rd_active), .rd_bit(rd_bit), .status_show(status_show),
    .idle(fe_idle)
  );

  seep_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .go(prog_go), .kind(prog_kind),
    .waddr(prog_addr), .wdata(prog_data), .raddr(look_addr), .rdata(rd_word)
  );

  seep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy)
  );

  assign dout_en = rd_active | status_show;
  assign dout    = rd_active ? rd_bit : (status_show & ~busy);
endmodule

// File: rtl/seep_chk.sv
module seep_chk #(
  parameter int BUSY_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_en,
  input logic busy,
  input logic idle,
  input logic rd_active
);
  localparam int LW = $clog2(BUSY_CYCLES + 2);

  logic [LW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R11
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout_en);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == LW'(BUSY_CYCLES)));

  // R9
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && busy) |-> !dout);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idle) |=> idle);

  // R4
  dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (dout_en && !dout));
endmodule

bind serial_eeprom_slave seep_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_seep_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_en(dout_en),
  .busy(busy), .idle(fe_idle), .rd_active(rd_active)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int BUSY = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_en;

  serial_eeprom_slave #(.WIDE_WORDS(1'b1), .TOTAL_BITS(1024), .BUSY_CYCLES(BUSY))
    i_serial_eeprom_slave (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
                           .dout(dout), .dout_en(dout_en));

  always #2 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  bit    run_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // reference state
  logic [15:0] mref [64];
  bit wen_ref = 1'b0;
  bit n_cs = 0, n_stat = 0, n_idle = 1, n_rd_oe = 0, n_rd_do = 0, n_go = 0;
  bit e_cs = 0, e_stat = 0, e_idle = 1, e_rd_oe = 0, e_rd_do = 0;
  int bl = 0;

  always @(posedge clk) begin
    e_cs <= n_cs; e_stat <= n_stat; e_idle <= n_idle;
    e_rd_oe <= n_rd_oe; e_rd_do <= n_rd_do;
    if (n_go) begin bl = BUSY; n_go = 0; end
    else if (bl > 0) bl = bl - 1;
  end

  always @(negedge clk) begin : cmp
    bit x_en, x_do;
    if (run_on && !done) begin
      x_en = e_rd_oe | (e_cs & e_stat & e_idle);
      x_do = e_rd_oe ? e_rd_do : (bl == 0);
      n_vec++;
      if (dout_en !== x_en) begin
        n_bad++;
        $display("FAIL %s dout_en got %b exp %b at %0t", cur_req, dout_en, x_en, $time);
      end
      if (x_en) begin
        n_vec++;
        if (dout !== x_do) begin
          n_bad++;
          $display("FAIL %s dout got %b exp %b at %0t", cur_req, dout, x_do, $time);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp, input string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rise(input logic b);
    di = b; sk = 1'b1;
  endtask

  task automatic low();
    sk = 1'b0; tick(2);
  endtask

  task automatic send(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                      input int lead, input int cut, output logic [15:0] got);
    bit ok, rd, hasd, cut_off;
    rd = (op == 2'b10);
    hasd = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    got = '0; cut_off = 1'b0;
    cs = 1'b1; n_cs = 1; tick(2);
    for (int i = 0; i < lead; i++) begin rise(1'b0); tick(2); low(); end
    ok = (bl == 0);
    rise(1'b1); if (ok) begin n_stat = 0; n_idle = 0; end tick(2); low();
    for (int i = 1; i >= 0; i--) begin rise(op[i]); tick(2); low(); end
    for (int i = 5; i >= 0; i--) begin
      rise(a[i]);
      if (i == 0 && rd && ok) begin n_rd_oe = 1; n_rd_do = 0; end
      tick(2);
      if (i == 0 && rd && ok) chk("R4", {30'd0, dout_en, dout}, 32'd2, "dummy bit");
      low();
    end
    if (rd && ok) begin
      for (int k = 15; k >= 0; k--) begin
        rise(1'b0); n_rd_do = mref[a][k]; tick(2); got[k] = dout; low();
      end
      rise(1'b0); n_rd_oe = 0; tick(2); low();
    end
    if (hasd) begin
      for (int k = 15; k >= 0; k--) begin
        if (cut >= 0 && (15 - k) >= cut) begin cut_off = 1'b1; break; end
        rise(d[k]); tick(2); low();
      end
      if (ok && !cut_off) chk("R12", {31'd0, dout_en}, 32'd0, "no drive during write");
    end
    cs = 1'b0; n_cs = 0; n_idle = 1; n_rd_oe = 0;
    if (ok && !cut_off && !rd) begin
      if (op == 2'b00 && a[5:4] == 2'b11) wen_ref = 1'b1;
      else if (op == 2'b00 && a[5:4] == 2'b00) wen_ref = 1'b0;
      else if (wen_ref) begin
        n_go = 1; n_stat = 1;
        case (op)
          2'b01: mref[a] = d;
          2'b11: mref[a] = 16'hFFFF;
          default: for (int w = 0; w < 64; w++) mref[w] = (a[5:4] == 2'b01) ? d : 16'hFFFF;
        endcase
      end
    end
    tick(3);
  endtask

  task automatic read_chk(input string req, input logic [5:0] a);
    logic [15:0] g;
    send(2'b10, a, 16'h0, 0, -1, g);
    chk(req, {16'd0, g}, {16'd0, mref[a]}, $sformatf("word %0d", a));
  endtask

  task automatic wait_ready();
    cs = 1'b1; n_cs = 1; tick(2);
    if (bl > 1) chk("R9", {30'd0, dout_en, dout}, 32'd2, "busy status");
    while (bl > 0) tick(1);
    tick(2);
    chk("R9", {30'd0, dout_en, dout}, 32'd3, "ready status");
    cs = 1'b0; n_cs = 0; tick(3);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    for (int w = 0; w < 64; w++) mref[w] = 16'hFFFF;
    tick(5); rst_n = 1'b1; run_on = 1'b1; tick(2);
    cur_req = "R1";
    chk("R1", {31'd0, dout_en}, 32'd0, "dout_en after reset");
    read_chk("R1", 6'd5);
    read_chk("R1", 6'd63);

    cur_req = "R8";
    send(2'b01, 6'd5, 16'h1234, 0, -1, g);
    cs = 1'b1; n_cs = 1; tick(6);
    chk("R8", {31'd0, dout_en}, 32'd0, "no status when blocked");
    cs = 1'b0; n_cs = 0; tick(3);
    read_chk("R8", 6'd5);

    cur_req = "R3";
    send(2'b00, 6'b110000, 16'h0, 0, -1, g);
    cur_req = "R2";
    send(2'b01, 6'd5, 16'hA55A, 3, -1, g);
    cur_req = "R9";
    wait_ready();
    cur_req = "R5";
    read_chk("R5", 6'd5);
    read_chk("R2", 6'd4);

    cur_req = "R10";
    send(2'b01, 6'd9, 16'h0F0F, 0, -1, g);
    send(2'b11, 6'd5, 16'h0, 0, -1, g);
    send(2'b10, 6'd9, 16'h0, 0, -1, g);
    wait_ready();
    read_chk("R10", 6'd5);
    read_chk("R5", 6'd9);

    cur_req = "R6";
    send(2'b11, 6'd9, 16'h0, 1, -1, g);
    wait_ready();
    read_chk("R6", 6'd9);

    cur_req = "R7";
    send(2'b00, 6'b010000, 16'h3C96, 0, -1, g);
    wait_ready();
    read_chk("R7", 6'd0);
    read_chk("R7", 6'd63);

    cur_req = "R6";
    send(2'b00, 6'b100000, 16'h0, 0, -1, g);
    wait_ready();
    read_chk("R6", 6'd17);

    cur_req = "R11";
    send(2'b01, 6'd2, 16'h00FF, 0, 8, g);
    chk("R11", {31'd0, dout_en}, 32'd0, "released after cs low");
    read_chk("R11", 6'd2);

    cur_req = "R8";
    send(2'b00, 6'b000000, 16'h0, 0, -1, g);
    send(2'b01, 6'd3, 16'h1111, 0, -1, g);
    read_chk("R8", 6'd3);

    cur_req = "R12";
    tick(4);
    chk("R12", {31'd0, dout_en}, 32'd0, "idle with cs low");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule